// File: doc/BRIEF.md
# Single-Pending External Interrupt Controller

This block sits between an external interrupt request line and the instruction sequencer of a core. When a request arrives and the core's interrupt-enable flag is set, the block raises a one-cycle take strobe and presents the interrupt vector address for the sequencer to load as its next program counter. When interrupts are masked, the block keeps exactly one request pending. It tries again to deliver it on every later cycle until the enable flag is found set.

The pending store has a single slot. A request that arrives while the slot is full and interrupts are masked is dropped. A request that arrives in the cycle in which the pending one is delivered is also dropped. Only a hardware reset or a delivery empties the slot, so a software re-initialisation of the core leaves a pending request in place. The pins are plain control signals. There is no valid/ready pairing and no back-pressure: the strobe is not acknowledged, and the sequencer must accept it in the cycle it is shown.

Top module: `irq_single_pend`

## Requirements
- R1: While and after reset (`rst_n` low), `take_o` is 0, `vector_o` is 0 and no request is pending.
- R2: A request sampled at a clock edge with `ie_i` high makes `take_o` high for exactly the following cycle. Requests on consecutive edges with `ie_i` high give strobes in consecutive cycles.
- R3: `vector_o` equals the parameter `VECTOR` (default 0xFFFFF138) in every cycle in which `take_o` is high, and 0 in every other cycle.
- R4: A request sampled with `ie_i` low and no request pending becomes pending. It is delivered at the first later edge that samples `ie_i` high, with `take_o` high in the cycle after that edge.
- R5: A pending request stays pending for any number of cycles while `ie_i` is low.
- R6: A request sampled with `ie_i` low while one is already pending is discarded. When enabled, exactly one strobe results.
- R7: An edge that samples `ie_i` high while a request is pending delivers it and empties the slot. A new request sampled at that same edge is discarded.
- R8: `take_o` is never high in the cycle after an edge that sampled `ie_i` low.
- R9: Asserting reset empties the pending slot, so enabling afterwards produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | External interrupt request, one cycle per request |
| ie_i | input | 1 | Interrupt-enable flag from the processor status word |
| take_o | output | 1 | One-cycle strobe: interrupt taken, load next PC from `vector_o` |
| vector_o | output | 32 | Next-PC vector while `take_o` is high, otherwise 0 |

## Verification
The bench runs several request patterns. A request with interrupts enabled checks the direct path and its one-cycle latency. A request while masked, followed by a long masked stretch, shows whether the slot holds and whether retry happens on the first enabled edge. Bursts of requests while masked, and a request that coincides with the enable edge, tell a single-slot controller apart from one that queues or counts. A reset during a pending request shows that the slot is cleared only by reset or delivery.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;
  localparam addr_t DEFAULT_VECTOR = 32'hFFFF_F138;
endpackage

// File: rtl/irq_decide.sv
module irq_decide (
  input  logic req_i,
  input  logic ie_i,
  input  logic pend_i,
  output logic deliver_o,
  output logic set_pend_o,
  output logic clr_pend_o
);
  // An enabled edge delivers either a fresh request or the pending one, never both.
  always_comb begin
    deliver_o  = ie_i & (req_i | pend_i);
    set_pend_o = ~ie_i & req_i & ~pend_i;
    clr_pend_o = ie_i & pend_i;
  end
endmodule

// File: rtl/irq_pend_slot.sv
module irq_pend_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (clr_i) pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
  end

  assign pend_o = pend_q;

  // R5
  hold_while_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ie_i) |=> pend_q);
  // R7
  empty_after_delivery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ie_i) |=> !pend_q);
endmodule

// File: rtl/irq_take_reg.sv
module irq_take_reg
  import irq_pkg::*;
#(
  parameter addr_t VECTOR = DEFAULT_VECTOR
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  deliver_i,
  output logic  take_o,
  output addr_t vector_o
);
  logic  take_q;
  addr_t vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= deliver_i;
      vec_q  <= deliver_i ? VECTOR : '0;
    end
  end

  assign take_o   = take_q;
  assign vector_o = vec_q;

  // R3
  vector_with_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> (vec_q == VECTOR));
  // R3
  vector_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_q |-> (vec_q == '0));
endmodule

// File: rtl/irq_single_pend.sv
module irq_single_pend
  import irq_pkg::*;
#(
  parameter addr_t VECTOR = DEFAULT_VECTOR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              ie_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vector_o
);
  logic pend;
  logic deliver;
  logic set_pend;
  logic clr_pend;

  irq_decide u_decide (
    .req_i      (req_i),
    .ie_i       (ie_i),
    .pend_i     (pend),
    .deliver_o  (deliver),
    .set_pend_o (set_pend),
    .clr_pend_o (clr_pend)
  );

  irq_pend_slot u_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_pend),
    .clr_i  (clr_pend),
    .ie_i   (ie_i),
    .pend_o (pend)
  );

  irq_take_reg #(.VECTOR(VECTOR)) u_take (
    .clk       (clk),
    .rst_n     (rst_n),
    .deliver_i (deliver),
    .take_o    (take_o),
    .vector_o  (vector_o)
  );

  // R2
  enabled_req_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && ie_i) |=> take_o);
  // R4
  masked_req_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !ie_i && !pend) |=> pend);
  // R8
  no_take_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_i |=> !take_o);
endmodule

// File: tb/irq_single_pend_tb.sv
module irq_single_pend_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        ie = 1'b0;
  logic        take;
  logic [31:0] vec;

  localparam logic [31:0] VEC = 32'hFFFF_F138;

  int    n_vec = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    m_pend = 1'b0;
  bit    m_take = 1'b0;
  int    n_takes = 0;

  always #10 clk = ~clk;

  irq_single_pend dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req),
    .ie_i     (ie),
    .take_o   (take),
    .vector_o (vec)
  );

  // Behavioural reference: one pending slot, one registered strobe.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 1'b0;
      m_take = 1'b0;
    end else if (ie) begin
      m_take = req || m_pend;
      m_pend = 1'b0;
    end else begin
      m_take = 1'b0;
      if (req) m_pend = 1'b1;
    end
  end

  task automatic step(input bit r, input bit e);
    logic [31:0] exp_vec;
    req = r;
    ie  = e;
    @(negedge clk);
    exp_vec = m_take ? VEC : 32'h0;
    n_vec++;
    if (take !== m_take) begin
      n_bad++;
      $display("FAIL %s take_o got %b expected %b", tag, take, m_take);
    end
    n_vec++;
    if (vec !== exp_vec) begin
      n_bad++;
      $display("FAIL R3 vector_o got %h expected %h", vec, exp_vec);
    end
    if (take === 1'b1) n_takes++;
  endtask

  task automatic count_check(input int exp_n);
    n_vec++;
    if (n_takes != exp_n) begin
      n_bad++;
      $display("FAIL %s strobe count got %0d expected %0d", tag, n_takes, exp_n);
    end
    n_takes = 0;
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog expired got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R1";
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    n_takes = 0;

    tag = "R2";
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    count_check(1);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    count_check(2);

    tag = "R4";
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    tag = "R5";
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0);
    count_check(0);
    tag = "R4";
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    count_check(1);

    tag = "R6";
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    count_check(1);

    tag = "R7";
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    count_check(1);

    tag = "R8";
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    count_check(0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    count_check(1);

    tag = "R9";
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    rst_n = 1'b0;
    step(1'b0, 1'b0);
    rst_n = 1'b1;
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    count_check(0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule